// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a small in-order, single-issue integer core that moves every instruction through five stages: fetch, register read with decode, execute, memory access and write-back. It runs a 32-bit subset made of register-to-register arithmetic and logic, word load, word store and branch-on-equal. The instruction memory, the data memory and a 32-entry register file all sit inside the core. While reset is held, a test environment fills both memories through a word-wide load port. When reset is released, the core starts fetching at address 0.

There is no forwarding, no stall and no prediction. Every instruction class takes the same path through the stages. An arithmetic result is carried through an idle memory stage, so the single register-file write port is only ever used in stage 5. Programs must keep dependent instructions at least three slots apart, which means two unrelated instructions or no-ops in between. They must also accept that the three instructions after a taken branch still complete. Two observation ports show what the core does: a write-back port that mirrors stage 5 and a store port that mirrors the memory stage.

Each instruction is decoded into a class. The classes act as the pipeline's states:
- BUBBLE: no effect.
- ALU: writes rd in stage 5.
- LOAD: reads memory in stage 4 and writes rt in stage 5.
- STORE: writes memory in stage 4.
- BRANCH: compares in stage 3 and redirects the PC in stage 4.

The class of an instruction moves forward one stage register per clock: IF/ID, then ID/EX, then EX/MEM, then MEM/WB. On reset, every stage register returns to BUBBLE.

Top module: `pipe5_core`

## Requirements
- R1: An active-high synchronous reset sets the PC to 0 and loads a bubble into every stage register, so both `wb_we` and `st_we` are low. After release, the first instruction fetched is word 0.
- R2: Opcode 0 selects an arithmetic or logic operation from funct: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than. The result is written to rd (bits 15:11). Call the rising edge at which fetch captures an instruction edge k. That instruction's register write shows on the write-back port after edge k+3, and its store, if any, shows on the store port after edge k+2.
- R3: Opcode 0x23 loads the data word at rs plus the sign-extended 16-bit immediate and writes it to rt (bits 20:16).
- R4: Opcode 0x2B writes rt to the data memory at rs plus the sign-extended immediate, shows the address and data on the store port, and writes no register.
- R5: Opcode 0x04 compares rs and rt. When they are equal, fetch is redirected to PC+4 plus the immediate times 4, after the three instructions that follow the branch have been fetched; those three still complete. When they differ, execution continues in sequence.
- R6: Register 0 always reads as 0, and a result aimed at register 0 produces no write (`wb_we` stays low).
- R7: A read in decode sees a value that stage 5 writes in the same cycle, so two intervening instructions are enough between a producer and its consumer.
- R8: A new instruction enters fetch on every clock and the PC steps by 4, so independent instructions issued back to back write back on consecutive cycles.
- R9: An unknown opcode, or opcode 0 with an unknown funct (including the all-zero word), behaves as a no-op: no register write, no store and no redirect.
- R10: The data memory is word-indexed by address bits from bit 2 upward, modulo its depth; the two lowest address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Write one preload word this cycle |
| load_sel | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| load_addr | input | LAW (6) | Word index for the preload write |
| load_data | input | 32 | Preload word |
| wb_we | output | 1 | Stage 5 writes a register this cycle |
| wb_addr | output | 5 | Destination register of the stage 5 write |
| wb_data | output | 32 | Value written in stage 5 |
| st_we | output | 1 | Memory stage writes data memory this cycle |
| st_addr | output | 32 | Byte address of the store |
| st_data | output | 32 | Word being stored |

## Verification
The bench targets the following corner cases and the faulty behaviour each one would expose:
- A producer followed after exactly two slots by its consumer. A register file that lacks same-cycle visibility would deliver the stale operand.
- A taken branch with three live shadow instructions. A core that squashed them, or redirected one cycle early or late, would drop or add a write-back in the expected stream.
- Writes aimed at register 0 and reads of register 0. A faulty core would raise `wb_we` or return a non-zero operand.
- Unaligned load addresses, signed set-less-than with a negative operand, a load that follows a store to the same word, and unknown encodings. These catch wrong indexing, unsigned comparison, lost stores and encodings that leak side effects.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

    localparam int XLEN = 32;
    localparam int RIDX = 5;

    localparam logic [5:0] OPC_ALU   = 6'h00;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;
    localparam logic [5:0] OPC_BEQ   = 6'h04;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        CLS_BUBBLE = 3'd0,
        CLS_ALU    = 3'd1,
        CLS_LOAD   = 3'd2,
        CLS_STORE  = 3'd3,
        CLS_BRANCH = 3'd4
    } icls_e;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_SLT = 3'd4
    } aluop_e;

    typedef struct packed {
        icls_e  cls;
        aluop_e op;
        logic   imm_b;
        logic   dst_rd;
        logic   mem_to_reg;
        logic   reg_we;
        logic   mem_we;
        logic   branch;
    } ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0] instr;
        logic [XLEN-1:0] pc4;
    } ifid_t;

    typedef struct packed {
        ctrl_t           c;
        logic [XLEN-1:0] pc4;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] imm;
        logic [RIDX-1:0] rt;
        logic [RIDX-1:0] rd;
    } idex_t;

    typedef struct packed {
        icls_e           cls;
        logic            reg_we;
        logic            mem_we;
        logic            m2r;
        logic            branch;
        logic            eq;
        logic [RIDX-1:0] dst;
        logic [XLEN-1:0] alu;
        logic [XLEN-1:0] sdata;
        logic [XLEN-1:0] tgt;
    } exmem_t;

    typedef struct packed {
        logic            we;
        logic            m2r;
        logic [RIDX-1:0] dst;
        logic [XLEN-1:0] alu;
        logic [XLEN-1:0] mdata;
    } memwb_t;

endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
    import pipe5_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctrl
);

    aluop_e fn_op;
    logic   fn_ok;

    always_comb begin
        fn_op = OP_ADD;
        fn_ok = 1'b1;
        unique case (instr[5:0])
            FN_ADD:  fn_op = OP_ADD;
            FN_SUB:  fn_op = OP_SUB;
            FN_AND:  fn_op = OP_AND;
            FN_OR:   fn_op = OP_OR;
            FN_SLT:  fn_op = OP_SLT;
            default: fn_ok = 1'b0;
        endcase
    end

    always_comb begin
        ctrl = '0;
        unique case (instr[31:26])
            OPC_ALU: begin
                if (fn_ok) begin
                    ctrl.cls    = CLS_ALU;
                    ctrl.op     = fn_op;
                    ctrl.dst_rd = 1'b1;
                    ctrl.reg_we = 1'b1;
                end
            end
            OPC_LOAD: begin
                ctrl.cls        = CLS_LOAD;
                ctrl.op         = OP_ADD;
                ctrl.imm_b      = 1'b1;
                ctrl.mem_to_reg = 1'b1;
                ctrl.reg_we     = 1'b1;
            end
            OPC_STORE: begin
                ctrl.cls    = CLS_STORE;
                ctrl.op     = OP_ADD;
                ctrl.imm_b  = 1'b1;
                ctrl.mem_we = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.cls    = CLS_BRANCH;
                ctrl.op     = OP_SUB;
                ctrl.branch = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
    import pipe5_pkg::*;
#(
    parameter int W = XLEN
) (
    input  aluop_e         op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);

    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
    parameter  int NREGS = 32,
    parameter  int W     = 32,
    parameter  int NRD   = 2,
    localparam int AW    = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr [NRD],
    output logic [W-1:0]  rdata [NRD]
);

    logic [W-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar gp = 0; gp < NRD; gp++) begin : g_rd
        always_comb begin
            if (raddr[gp] == '0)
                rdata[gp] = '0;
            else if (we && (raddr[gp] == waddr))
                rdata[gp] = wdata;
            else
                rdata[gp] = regs[raddr[gp]];
        end
    end

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter  int IMEM_WORDS = 64,
    parameter  int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_en,
    input  logic            load_sel,
    input  logic [LAW-1:0]  load_addr,
    input  logic [XLEN-1:0] load_data,
    output logic            wb_we,
    output logic [RIDX-1:0] wb_addr,
    output logic [XLEN-1:0] wb_data,
    output logic            st_we,
    output logic [XLEN-1:0] st_addr,
    output logic [XLEN-1:0] st_data
);

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0] pc;
    ifid_t           ifid;
    idex_t           idex;
    exmem_t          exmem;
    memwb_t          memwb;

    ctrl_t           dec_ctrl;
    logic [RIDX-1:0] rf_ra [2];
    logic [XLEN-1:0] rf_rd [2];
    logic [XLEN-1:0] wb_value;
    logic [XLEN-1:0] ex_b;
    logic [XLEN-1:0] ex_y;
    logic [XLEN-1:0] mem_rdata;
    logic            br_taken;

    // preload port and store path
    always_ff @(posedge clk) begin
        if (load_en && !load_sel)
            imem[load_addr[IAW-1:0]] <= load_data;
    end

    always_ff @(posedge clk) begin
        if (load_en && load_sel)
            dmem[load_addr[DAW-1:0]] <= load_data;
        else if (exmem.mem_we)
            dmem[exmem.alu[DAW+1:2]] <= exmem.sdata;
    end

    // decode and register read
    pipe5_decode u_dec (
        .instr (ifid.instr),
        .ctrl  (dec_ctrl)
    );

    assign rf_ra[0] = ifid.instr[25:21];
    assign rf_ra[1] = ifid.instr[20:16];

    pipe5_regfile #(.NREGS(1 << RIDX), .W(XLEN), .NRD(2)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (memwb.we),
        .waddr (memwb.dst),
        .wdata (wb_value),
        .raddr (rf_ra),
        .rdata (rf_rd)
    );

    // execute
    assign ex_b = idex.c.imm_b ? idex.imm : idex.b;

    pipe5_alu #(.W(XLEN)) u_alu (
        .op (idex.c.op),
        .a  (idex.a),
        .b  (ex_b),
        .y  (ex_y)
    );

    // memory stage
    assign br_taken  = exmem.branch & exmem.eq;
    assign mem_rdata = dmem[exmem.alu[DAW+1:2]];

    // write-back
    assign wb_value = memwb.m2r ? memwb.mdata : memwb.alu;

    // stage registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= '0;
            ifid  <= '0;
            idex  <= '0;
            exmem <= '0;
            memwb <= '0;
        end else begin
            pc         <= br_taken ? exmem.tgt : pc + 32'd4;

            ifid.instr <= imem[pc[IAW+1:2]];
            ifid.pc4   <= pc + 32'd4;

            idex.c     <= dec_ctrl;
            idex.pc4   <= ifid.pc4;
            idex.a     <= rf_rd[0];
            idex.b     <= rf_rd[1];
            idex.imm   <= {{16{ifid.instr[15]}}, ifid.instr[15:0]};
            idex.rt    <= ifid.instr[20:16];
            idex.rd    <= ifid.instr[15:11];

            exmem.cls    <= idex.c.cls;
            exmem.reg_we <= idex.c.reg_we;
            exmem.mem_we <= idex.c.mem_we;
            exmem.m2r    <= idex.c.mem_to_reg;
            exmem.branch <= idex.c.branch;
            exmem.eq     <= (idex.a == idex.b);
            exmem.dst    <= idex.c.dst_rd ? idex.rd : idex.rt;
            exmem.alu    <= ex_y;
            exmem.sdata  <= idex.b;
            exmem.tgt    <= idex.pc4 + {idex.imm[XLEN-3:0], 2'b00};

            memwb.we     <= exmem.reg_we && (exmem.dst != '0);
            memwb.m2r    <= exmem.m2r;
            memwb.dst    <= exmem.dst;
            memwb.alu    <= exmem.alu;
            memwb.mdata  <= mem_rdata;
        end
    end

    // observation outputs
    always_comb begin
        wb_we   = memwb.we;
        wb_addr = memwb.dst;
        wb_data = wb_value;
        st_we   = exmem.mem_we;
        st_addr = exmem.alu;
        st_data = exmem.sdata;
    end

    assert_wb_never_r0_R6: assert property (@(posedge clk) disable iff (rst)
        wb_we |-> (wb_addr != '0))
        else $error("write-back aimed at register 0");

    assert_branch_redirect_R5: assert property (@(posedge clk) disable iff (rst)
        br_taken |=> (pc == $past(exmem.tgt)))
        else $error("taken branch did not load its target");

    assert_pc_advance_R8: assert property (@(posedge clk) disable iff (rst)
        !br_taken |=> (pc == $past(pc) + 32'd4))
        else $error("PC did not step by 4");

    assert_store_no_regwrite_R4: assert property (@(posedge clk) disable iff (rst)
        (exmem.cls == CLS_STORE) |=> !wb_we)
        else $error("store produced a register write");

    assert_load_dest_R3: assert property (@(posedge clk) disable iff (rst)
        ((exmem.cls == CLS_LOAD) && (exmem.dst != '0)) |=>
            (wb_we && (wb_addr == $past(exmem.dst))))
        else $error("load did not write its destination");

    assert_bubble_inert_R9: assert property (@(posedge clk) disable iff (rst)
        (idex.c.cls == CLS_BUBBLE) |=> (!exmem.reg_we && !exmem.mem_we && !exmem.branch))
        else $error("bubble carried a side effect");

endmodule

// File: tb/pipe5_core_test.sv
`timescale 1ns/1ps
module pipe5_core_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        load_en;
    logic        load_sel;
    logic [5:0]  load_addr;
    logic [31:0] load_data;
    logic        wb_we;
    logic [4:0]  wb_addr;
    logic [31:0] wb_data;
    logic        st_we;
    logic [31:0] st_addr;
    logic [31:0] st_data;

    always #10 clk = ~clk;

    pipe5_core uut (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_sel  (load_sel),
        .load_addr (load_addr),
        .load_data (load_data),
        .wb_we     (wb_we),
        .wb_addr   (wb_addr),
        .wb_data   (wb_data),
        .st_we     (st_we),
        .st_addr   (st_addr),
        .st_data   (st_data)
    );

    int vectors    = 0;
    int miscompares = 0;
    bit finished   = 1'b0;

    typedef struct {
        logic        we;
        logic [4:0]  a;
        logic [31:0] d;
        logic        sw;
        logic [31:0] sa;
        logic [31:0] sd;
        string       tag;
    } exp_t;

    exp_t        pq [4];
    logic [31:0] prog [64];
    logic [31:0] m_dm [64];
    logic [31:0] m_rf [32];
    logic [31:0] m_pc;
    int          pend;
    logic [31:0] ptgt;

    function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, int imm);
        logic [31:0] t;
        t = imm;
        return {op, rs, rt, t[15:0]};
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step_model();
        exp_t        e;
        logic [31:0] ins, a, b, simm, ea, r, nxt;
        logic [4:0]  rs, rt, rd;
        bit          ok, inslot;
        ins  = prog[m_pc[7:2]];
        rs   = ins[25:21];
        rt   = ins[20:16];
        rd   = ins[15:11];
        simm = {{16{ins[15]}}, ins[15:0]};
        a    = m_rf[rs];
        b    = m_rf[rt];
        ea   = a + simm;
        inslot = (pend > 0);
        e.we = 1'b0; e.a = '0; e.d = '0; e.sw = 1'b0; e.sa = '0; e.sd = '0; e.tag = "R9";
        r  = '0;
        ok = 1'b1;
        case (ins[31:26])
            6'h00: begin
                case (ins[5:0])
                    6'h20: r = a + b;
                    6'h22: r = a - b;
                    6'h24: r = a & b;
                    6'h25: r = a | b;
                    6'h2A: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default: ok = 1'b0;
                endcase
                if (ok) begin
                    e.we = (rd != 0); e.a = rd; e.d = r;
                    if (rd != 0) m_rf[rd] = r;
                    e.tag = (rd == 0 || rs == 0 || rt == 0) ? "R6" : "R2 R8";
                end
            end
            6'h23: begin
                r = m_dm[ea[7:2]];
                e.we = (rt != 0); e.a = rt; e.d = r;
                if (rt != 0) m_rf[rt] = r;
                e.tag = (ea[1:0] != 2'b00) ? "R10" : "R3";
            end
            6'h2B: begin
                e.sw = 1'b1; e.sa = ea; e.sd = b;
                m_dm[ea[7:2]] = b;
                e.tag = "R4";
            end
            6'h04: begin
                e.tag = "R5";
                if (a == b) begin
                    pend = 4;
                    ptgt = m_pc + 32'd4 + {simm[29:0], 2'b00};
                end
            end
            default: ;
        endcase
        if (inslot) e.tag = {"R5 ", e.tag};
        nxt = m_pc + 32'd4;
        if (pend > 0) begin
            pend--;
            if (pend == 0) nxt = ptgt;
        end
        m_pc  = nxt;
        pq[3] = pq[2];
        pq[2] = pq[1];
        pq[1] = pq[0];
        pq[0] = e;
    endtask

    task automatic compare_outputs();
        chk(pq[3].tag, "wb_we", {31'd0, wb_we}, {31'd0, pq[3].we});
        if (pq[3].we) begin
            chk(pq[3].tag, "wb_addr", {27'd0, wb_addr}, {27'd0, pq[3].a});
            chk(pq[3].tag, "wb_data", wb_data, pq[3].d);
        end
        chk(pq[2].tag, "st_we", {31'd0, st_we}, {31'd0, pq[2].sw});
        if (pq[2].sw) begin
            chk(pq[2].tag, "st_addr", st_addr, pq[2].sa);
            chk(pq[2].tag, "st_data", st_data, pq[2].sd);
        end
    endtask

    initial begin
        #(20 * 5000);
        if (!finished) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; load_en = 1'b0; load_sel = 1'b0; load_addr = '0; load_data = '0;
        for (int i = 0; i < 64; i++) begin prog[i] = '0; m_dm[i] = '0; end
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        for (int i = 0; i < 4; i++) begin
            pq[i].we = 1'b0; pq[i].a = '0; pq[i].d = '0;
            pq[i].sw = 1'b0; pq[i].sa = '0; pq[i].sd = '0; pq[i].tag = "R1";
        end
        m_pc = '0; pend = 0; ptgt = '0;

        m_dm[0] = 32'd5;
        m_dm[1] = 32'hFFFF_FFFD;

        prog[0]  = enc_i(6'h23, 5'd0, 5'd1, 0);          // r1 = 5
        prog[1]  = enc_i(6'h23, 5'd0, 5'd2, 4);          // r2 = -3
        prog[4]  = enc_r(5'd1, 5'd2, 5'd3, 6'h20);       // R7: two slots after r2
        prog[5]  = enc_r(5'd1, 5'd2, 5'd4, 6'h22);
        prog[6]  = enc_r(5'd1, 5'd2, 5'd5, 6'h24);
        prog[7]  = enc_r(5'd1, 5'd2, 5'd6, 6'h25);
        prog[8]  = enc_r(5'd2, 5'd1, 5'd7, 6'h2A);       // signed: -3 < 5
        prog[9]  = enc_r(5'd1, 5'd1, 5'd0, 6'h20);       // R6 write to r0
        prog[10] = {6'h3F, 26'h123_4567};                // R9 unknown opcode
        prog[11] = enc_r(5'd0, 5'd1, 5'd8, 6'h20);       // R6 read r0
        prog[12] = enc_i(6'h2B, 5'd1, 5'd3, 3);          // store r3 at 8
        prog[13] = enc_i(6'h23, 5'd0, 5'd15, 1);         // R10 unaligned
        prog[14] = enc_i(6'h04, 5'd1, 5'd1, 10);         // taken to 100
        prog[15] = enc_r(5'd1, 5'd1, 5'd9, 6'h20);
        prog[16] = enc_r(5'd1, 5'd2, 5'd10, 6'h2A);
        prog[17] = enc_r(5'd3, 5'd3, 5'd11, 6'h20);
        prog[18] = enc_r(5'd1, 5'd1, 5'd12, 6'h20);      // skipped
        prog[25] = enc_i(6'h23, 5'd0, 5'd13, 8);         // reads stored word
        prog[26] = enc_i(6'h04, 5'd1, 5'd2, 5);          // not taken
        prog[27] = enc_r(5'd2, 5'd1, 5'd14, 6'h22);
        prog[28] = enc_i(6'h04, 5'd0, 5'd0, -1);         // self loop

        @(negedge clk);
        @(negedge clk);
        chk("R1", "wb_we in reset", {31'd0, wb_we}, 32'd0);
        chk("R1", "st_we in reset", {31'd0, st_we}, 32'd0);

        for (int i = 0; i < 64; i++) begin
            load_en = 1'b1; load_sel = 1'b0; load_addr = i[5:0]; load_data = prog[i];
            @(negedge clk);
        end
        for (int i = 0; i < 64; i++) begin
            load_en = 1'b1; load_sel = 1'b1; load_addr = i[5:0]; load_data = m_dm[i];
            @(negedge clk);
        end
        load_en = 1'b0;
        chk("R1", "wb_we before release", {31'd0, wb_we}, 32'd0);
        rst = 1'b0;

        for (int n = 0; n < 64; n++) begin
            @(negedge clk);
            step_model();
            compare_outputs();
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule